// File: doc/BRIEF.md
# SCSI Initiator Phase-Change Monitor

This block sits beside an initiator's transfer logic and watches the bus phase lines (MSG, C/D, I/O), BSY and REQ. A change on the phase lines must survive two back-to-back qualification windows before it counts. The first window checks that the lines stay at the new value. The second checks that BSY stays asserted. When both windows pass, the block raises a bus-service interrupt. If BSY was seen low in the second window, it raises a disconnect interrupt instead. A REQ rising edge while the external transfer counter reads zero raises a bus-service interrupt that reports counter overflow.

A processor-side strobe interface drives the block. A control write sets the REQ-gating option. With that option on, a qualified phase change raises its interrupt only once REQ is asserted. Two read strobes mark reads of the auxiliary status register and of the interrupt register, and a command strobe issues a disconnect. The phase lines are copied into the auxiliary status register only while the interrupt is active. A further interrupt is held off until both registers have been read.

Top module: `scsi_phase_mon`

## Requirements
- R1: After reset, irq_o is 0, cause_o is 3'b000, aux_phase_o is 3'b000, the reference phase is 3'b000 and REQ gating is off.
- R2: A phase change applied before clock edge E0 is detected at E0. It is then checked over 12 edges and BSY over a further 12 edges, so irq_o rises after edge E24 and not after E23.
- R3: If the phase lines hold the new value through the first window and BSY is 1 at every sample of the second window, the interrupt carries cause_o = 3'b001 (bus service, bit 0).
- R4: If the phase lines differ from the new value at any sample of the first window, the monitor returns to idle without raising anything.
- R5: If BSY is 0 at any sample of the second window, the interrupt carries cause_o = 3'b010 (disconnect, bit 1).
- R6: Control bit 3 enables REQ gating. When it is 1 and REQ is 0 at the end of the second window, the monitor waits. It raises bus service on the first edge that sees REQ = 1, or disconnect if BSY falls first. When the bit is 0, REQ has no effect.
- R7: aux_phase_o loads phase_i (bit 2 MSG, bit 1 C/D, bit 0 I/O) on the raising edge and on every edge while irq_o is 1, and holds its value while irq_o is 0.
- R8: After an interrupt, no new interrupt is raised and no phase change is detected until both aux_rd_i and irq_rd_i have been pulsed, in either order.
- R9: With cnt_zero_i = 1 and the monitor idle and not held off, a rising edge of req_i raises irq_o on that clock edge with cause_o = 3'b100 (overflow, bit 2).
- R10: A disc_cmd_i pulse clears irq_o and ends the hold-off at that edge.
- R11: An irq_rd_i pulse clears irq_o at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | 3 | Synchronized phase lines {MSG, C/D, I/O} |
| bsy_i | input | 1 | Synchronized BSY, 1 = asserted |
| req_i | input | 1 | Synchronized REQ, 1 = asserted |
| cnt_zero_i | input | 1 | Transfer counter reads zero |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data, bit 3 = REQ gating |
| aux_rd_i | input | 1 | Auxiliary status register read strobe |
| irq_rd_i | input | 1 | Interrupt register read strobe |
| disc_cmd_i | input | 1 | Disconnect command strobe |
| irq_o | output | 1 | Interrupt request |
| aux_phase_o | output | 3 | Latched phase in auxiliary status |
| cause_o | output | 3 | {overflow, disconnect, bus service} |

## Verification
The assertions assume that phase_i, bsy_i and req_i are already synchronized to clk_i. They also assume that each strobe is a single-cycle pulse, and that REQ does not rise with cnt_zero_i set while a phase window is open. The stimulus changes every input at the falling clock edge and drives strobes for exactly one cycle. It raises REQ with the counter at zero only while the monitor is idle. In the random phase trials the counter-zero input is held at 0, so a REQ edge there cannot be taken for overflow.

// File: rtl/scsi_phase_mon_pkg.sv
package scsi_phase_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH   = 2'd1,
    ST_BSY  = 2'd2,
    ST_REQ  = 2'd3
  } mon_state_e;

  localparam int unsigned CAUSE_W   = 3;
  localparam int unsigned CAUSE_SVC = 0;
  localparam int unsigned CAUSE_DSC = 1;
  localparam int unsigned CAUSE_OVF = 2;
  localparam int unsigned GATE_BIT  = 3;
endpackage

// File: rtl/pmon_window.sv
module pmon_window #(
  parameter int unsigned LEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == LAST);

  assert_win_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !last_o || (LEN == 1));
endmodule

// File: rtl/pmon_irq.sv
module pmon_irq
  import scsi_phase_mon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               raise_i,
  input  logic [CAUSE_W-1:0] raise_cause_i,
  input  logic [2:0]         phase_i,
  input  logic               aux_rd_i,
  input  logic               irq_rd_i,
  input  logic               disc_cmd_i,
  output logic               irq_o,
  output logic               held_o,
  output logic [2:0]         aux_phase_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic irq_q, held_q, aux_seen_q, irq_seen_q;
  logic [2:0] aux_q;
  logic [CAUSE_W-1:0] cause_q;
  logic aux_seen_d, irq_seen_d;

  assign aux_seen_d = aux_seen_q | aux_rd_i;
  assign irq_seen_d = irq_seen_q | irq_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q      <= 1'b0;
      held_q     <= 1'b0;
      aux_seen_q <= 1'b0;
      irq_seen_q <= 1'b0;
      cause_q    <= '0;
    end else if (disc_cmd_i) begin
      irq_q      <= 1'b0;
      held_q     <= 1'b0;
      aux_seen_q <= 1'b0;
      irq_seen_q <= 1'b0;
    end else if (raise_i && !held_q) begin
      irq_q      <= 1'b1;
      held_q     <= 1'b1;
      aux_seen_q <= 1'b0;
      irq_seen_q <= 1'b0;
      cause_q    <= raise_cause_i;
    end else begin
      if (irq_rd_i) irq_q <= 1'b0;
      if (held_q && aux_seen_d && irq_seen_d) begin
        held_q     <= 1'b0;
        aux_seen_q <= 1'b0;
        irq_seen_q <= 1'b0;
      end else if (held_q) begin
        aux_seen_q <= aux_seen_d;
        irq_seen_q <= irq_seen_d;
      end
    end
  end

  // phase copied only at interrupt time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                aux_q <= '0;
    else if ((raise_i && !held_q) || irq_q)     aux_q <= phase_i;
  end

  assign irq_o       = irq_q;
  assign held_o      = held_q;
  assign aux_phase_o = aux_q;
  assign cause_o     = cause_q;

  assert_aux_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |=> (irq_o || $stable(aux_phase_o)));
  assert_no_raise_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> !raise_i);
  assert_disc_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_cmd_i |=> (!irq_o && !held_o));
  assert_rd_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_rd_i && !disc_cmd_i) |=> !irq_o);
endmodule

// File: rtl/scsi_phase_mon.sv
module scsi_phase_mon
  import scsi_phase_mon_pkg::*;
#(
  parameter int unsigned PH_QUAL  = 12,
  parameter int unsigned BSY_QUAL = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         phase_i,
  input  logic               bsy_i,
  input  logic               req_i,
  input  logic               cnt_zero_i,
  input  logic               ctrl_we_i,
  input  logic [7:0]         ctrl_wdata_i,
  input  logic               aux_rd_i,
  input  logic               irq_rd_i,
  input  logic               disc_cmd_i,
  output logic               irq_o,
  output logic [2:0]         aux_phase_o,
  output logic [CAUSE_W-1:0] cause_o
);
  mon_state_e state_q, state_d;
  logic [2:0] ref_q, cand_q;
  logic gate_q, req_q, bsy_low_q, held;
  logic ph_last, bsy_last, ph_start, bsy_start, ph_match;
  logic raise;
  logic [CAUSE_W-1:0] raise_cause;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gate_q <= 1'b0;
    else if (ctrl_we_i) gate_q <= ctrl_wdata_i[GATE_BIT];
  end

  assign ph_match  = (phase_i == cand_q);
  assign ph_start  = (state_q == ST_IDLE) && (state_d == ST_PH);
  assign bsy_start = (state_q == ST_PH) && (state_d == ST_BSY);

  pmon_window #(.LEN(PH_QUAL)) u_ph_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ph_start),
    .run_i  ((state_q == ST_PH) && ph_match),
    .last_o (ph_last)
  );

  pmon_window #(.LEN(BSY_QUAL)) u_bsy_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(bsy_start),
    .run_i  (state_q == ST_BSY),
    .last_o (bsy_last)
  );

  always_comb begin
    state_d     = state_q;
    raise       = 1'b0;
    raise_cause = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (!held && phase_i != ref_q) begin
          state_d = ST_PH;
        end else if (!held && cnt_zero_i && req_i && !req_q) begin
          raise                  = 1'b1;
          raise_cause[CAUSE_OVF] = 1'b1;
        end
      end
      ST_PH: begin
        if (!ph_match)    state_d = ST_IDLE;
        else if (ph_last) state_d = ST_BSY;
      end
      ST_BSY: begin
        if (bsy_last) begin
          if (bsy_low_q || !bsy_i) begin
            state_d                = ST_IDLE;
            raise                  = 1'b1;
            raise_cause[CAUSE_DSC] = 1'b1;
          end else if (gate_q && !req_i) begin
            state_d = ST_REQ;
          end else begin
            state_d                = ST_IDLE;
            raise                  = 1'b1;
            raise_cause[CAUSE_SVC] = 1'b1;
          end
        end
      end
      ST_REQ: begin
        if (!bsy_i) begin
          state_d                = ST_IDLE;
          raise                  = 1'b1;
          raise_cause[CAUSE_DSC] = 1'b1;
        end else if (req_i) begin
          state_d                = ST_IDLE;
          raise                  = 1'b1;
          raise_cause[CAUSE_SVC] = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ref_q     <= '0;
      cand_q    <= '0;
      req_q     <= 1'b0;
      bsy_low_q <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_i;
      if (ph_start)  cand_q <= phase_i;
      if (bsy_start) begin
        ref_q     <= cand_q;
        bsy_low_q <= 1'b0;
      end else if (state_q == ST_BSY && !bsy_i) begin
        bsy_low_q <= 1'b1;
      end
    end
  end

  pmon_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raise_i      (raise),
    .raise_cause_i(raise_cause),
    .phase_i      (phase_i),
    .aux_rd_i     (aux_rd_i),
    .irq_rd_i     (irq_rd_i),
    .disc_cmd_i   (disc_cmd_i),
    .irq_o        (irq_o),
    .held_o       (held),
    .aux_phase_o  (aux_phase_o),
    .cause_o      (cause_o)
  );

  assert_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH && !ph_match) |=> (state_q == ST_IDLE && $stable(ref_q)));
  assert_ref_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH && ph_last) |=> (ref_q == $past(phase_i)));
  assert_gate_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise && raise_cause[CAUSE_SVC] && gate_q) |-> req_i);
  assert_one_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise |-> $onehot(raise_cause));
  assert_svc_bsy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise && raise_cause[CAUSE_SVC]) |-> bsy_i);
endmodule

// File: tb/scsi_phase_mon_tb.sv
module scsi_phase_mon_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] phase = 3'b000;
  logic       bsy = 1'b1, req = 1'b0, cnt_zero = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       aux_rd = 1'b0, irq_rd = 1'b0, disc_cmd = 1'b0;
  logic       irq;
  logic [2:0] aux_phase, cause;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scsi_phase_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .bsy_i(bsy), .req_i(req),
    .cnt_zero_i(cnt_zero), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .aux_rd_i(aux_rd), .irq_rd_i(irq_rd), .disc_cmd_i(disc_cmd),
    .irq_o(irq), .aux_phase_o(aux_phase), .cause_o(cause)
  );

  function automatic logic [2:0] exp_cause(input logic bsy_held);
    return bsy_held ? 3'b001 : 3'b010;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic service();
    aux_rd = 1'b1; tick(1); aux_rd = 1'b0;
    irq_rd = 1'b1; tick(1); irq_rd = 1'b0;
  endtask

  task automatic wait_irq(input int max);
    for (int i = 0; i < max && !irq; i++) tick(1);
  endtask

  initial begin
    logic [2:0] cur;
    logic [2:0] nxt;
    logic hold;
    void'($urandom(32'd1234));
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1
    chk("R1 irq", irq, 0);
    chk("R1 cause", cause, 0);
    chk("R1 aux", aux_phase, 0);

    // R2 R3 exact latency
    phase = 3'b011; tick(24);
    chk("R2 not before E24", irq, 0);
    tick(1);
    chk("R2 irq after E24", irq, 1);
    chk("R3 cause svc", cause, 3'b001);
    chk("R7 aux on raise", aux_phase, 3'b011);
    service();
    chk("R11 irq cleared", irq, 0);

    // R4 glitch
    phase = 3'b111; tick(5); phase = 3'b011; tick(40);
    chk("R4 no irq on revert", irq, 0);

    // R7 aux holds while irq low, then R5 mid-window BSY drop
    phase = 3'b110; tick(10);
    chk("R7 aux hold", aux_phase, 3'b011);
    tick(8); bsy = 1'b0; tick(1); bsy = 1'b1;
    wait_irq(20);
    chk("R5 irq", irq, 1);
    chk("R5 cause disc", cause, 3'b010);
    chk("R7 aux new", aux_phase, 3'b110);
    service();

    // R6 REQ gating
    ctrl_we = 1'b1; ctrl_wdata = 8'h08; tick(1); ctrl_we = 1'b0;
    phase = 3'b010; tick(35);
    chk("R6 wait for req", irq, 0);
    req = 1'b1; tick(1);
    chk("R6 irq on req", irq, 1);
    chk("R6 cause svc", cause, 3'b001);
    req = 1'b0; service();
    phase = 3'b001; tick(35);
    chk("R6 still waiting", irq, 0);
    bsy = 1'b0; tick(1);
    chk("R6 bsy drop irq", irq, 1);
    chk("R6 cause disc", cause, 3'b010);
    bsy = 1'b1; service();
    ctrl_we = 1'b1; ctrl_wdata = 8'hF7; tick(1); ctrl_we = 1'b0;

    // R8 / R11 hold-off
    phase = 3'b100; wait_irq(30);
    chk("R3 irq", irq, 1);
    irq_rd = 1'b1; tick(1); irq_rd = 1'b0;
    chk("R11 rd clears", irq, 0);
    phase = 3'b101; tick(40);
    chk("R8 held off", irq, 0);
    aux_rd = 1'b1; tick(1); aux_rd = 1'b0;
    tick(25);
    chk("R8 after service", irq, 1);
    chk("R8 aux", aux_phase, 3'b101);

    // R10 disconnect command
    disc_cmd = 1'b1; tick(1); disc_cmd = 1'b0;
    chk("R10 irq cleared", irq, 0);

    // R9 overflow
    cnt_zero = 1'b1; req = 1'b1; tick(1);
    chk("R9 irq", irq, 1);
    chk("R9 cause ovf", cause, 3'b100);
    req = 1'b0; cnt_zero = 1'b0; service();
    req = 1'b1; tick(3); req = 1'b0; tick(1);
    chk("R9 no ovf when nonzero", irq, 0);

    // random phase trials
    cur = 3'b101;
    for (int t = 0; t < 24; t++) begin
      nxt = 3'($urandom_range(0, 7));
      if (nxt == cur) nxt = cur ^ 3'b001;
      hold = 1'($urandom_range(0, 1));
      bsy = hold; phase = nxt;
      wait_irq(40);
      chk("R3 rand irq", irq, 1);
      chk(hold ? "R3 rand cause" : "R5 rand cause", cause, exp_cause(hold));
      chk("R7 rand aux", aux_phase, nxt);
      bsy = 1'b1;
      service();
      cur = nxt;
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule